// File: doc/BRIEF.md
# Sampled-Insertion L1 Controller

This block controls a direct-mapped first-level cache that has a small fully-associative side filter. It holds the tag, valid and dirty state of both structures; the data arrays and the second-level cache are outside it. The CPU presents one line address at a time. The block checks the L1 tags first. If the line is not there, it searches all filter entries at once. If that also misses, it asks L2 for the line and waits for the fill.

The block keeps no reuse history per line. For each reference that misses in L1, a modulo counter of L1 misses decides where the line ends up. When the counter fires, the line is placed in L1, whether it came from the filter or from L2. Otherwise the line stays in the filter or is filled into it. Over time a line that is referenced often collects many chances at the counter and settles in L1, while short-lived lines churn through the filter. A configuration input picks one of two sampling periods, one tuned for data traffic and one for instruction traffic.

Each request produces one response. The response reports where the line was found and whether the line now lives in L1. When an insertion displaces a dirty line, the response also carries a write-back of that line to L2.

Top module: `rfl_ctrl`

## Requirements
- R1: After reset, `req_ready` is high and `resp_valid`, `l2_req_valid` and `wb_valid` are low. All L1 and filter entries are invalid and the sampling count is zero.
- R2: A reference whose line is valid in the L1 set selected by the low `log2(L1_SETS)` bits of the line address responds one cycle after acceptance with `resp_src`=1 and `resp_to_l1`=1. It issues no L2 request and does not advance the sampling count.
- R3: A reference that misses in L1, hits in the filter and is not selected responds one cycle after acceptance with `resp_src`=2 and `resp_to_l1`=0. It issues no L2 request and leaves the line in its filter entry.
- R4: A reference that misses in both structures pulses `l2_req_valid` for one cycle, one cycle after acceptance, with `l2_req_line` equal to the requested line. The response follows one cycle after the cycle in which `l2_rsp_valid` is high, with `resp_src`=3.
- R5: Only references that miss in L1 advance the sampling count. Such a reference is selected when the count, before it advances, is at least the active period minus one; the count then returns to zero, and otherwise it increments. A selected reference ends with the line in L1 and `resp_to_l1`=1.
- R6: `cfg_instr`=0 makes the period `DATA_PERIOD` and `cfg_instr`=1 makes it `INSTR_PERIOD`.
- R7: A selected filter hit moves the line into L1 and invalidates its filter entry, so that slot is the first to be refilled. The L1 copy is dirty if the filter copy was dirty or the reference writes.
- R8: When a line is placed in L1 and the displaced L1 line is valid and dirty, `wb_valid` is raised together with the response and `wb_line` holds the displaced line. A clean displaced line is dropped without a write-back.
- R9: An unselected L2 fill goes into the lowest-numbered invalid filter entry. If all entries are valid, it goes into the entry named by a round-robin pointer. The pointer starts at 0 and advances by one, modulo `FILT_LINES`, on each such replacement. A dirty replaced filter line is written back as in R8.
- R10: A write sets the dirty state of the line in whichever structure holds it after the reference. A fill caused by a write is installed dirty.
- R11: `req_ready` is low from the cycle after acceptance until the response. It is high again in the cycle `resp_valid` is high, and each accepted request gives exactly one response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_instr | input | 1 | 0 selects the data sampling period, 1 the instruction period |
| req_valid | input | 1 | CPU reference present |
| req_ready | output | 1 | Controller can accept a reference |
| req_line | input | LINE_W | Line address of the reference (byte offset removed) |
| req_write | input | 1 | Reference is a store |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_src | output | 2 | 1 = L1 hit, 2 = filter hit, 3 = filled from L2 |
| resp_to_l1 | output | 1 | The line is held in L1 after this reference |
| l2_req_valid | output | 1 | One-cycle line request to L2 |
| l2_req_line | output | LINE_W | Line requested from L2 |
| l2_rsp_valid | input | 1 | L2 has returned the requested line |
| wb_valid | output | 1 | Dirty victim is sent to L2 |
| wb_line | output | LINE_W | Line address of the dirty victim |

## Verification
An L1 hit or a filter hit responds one cycle after the acceptance edge. An L2 miss raises its request one cycle after acceptance and responds one cycle after the edge at which the fill is presented. The fill is deliberately delayed by a varying number of cycles. The driver records the exact cycle each response is due and queues it with the expected source, the L1 placement and any write-back. The monitor samples at the falling edge and compares the response's cycle number with the due cycle, so a response that comes early or late fails even when its contents are correct.

// File: rtl/rfl_pkg.sv
// Shared codes for the sampled-insertion L1 controller.
// Assumes: response source codes are part of the port contract.
package rfl_pkg;
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_L1   = 2'd1,
        SRC_FILT = 2'd2,
        SRC_L2   = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_WAIT = 2'd2
    } state_e;
endpackage

// File: rtl/rfl_sampler.sv
// Periodic selection counter: counts L1-missing references and fires on
// each one whose pre-advance count reaches the active period minus one.
// Assumes: both periods are at least 1.
module rfl_sampler #(
    parameter int unsigned DATA_PERIOD  = 20,
    parameter int unsigned INSTR_PERIOD = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_instr,
    input  logic step,
    output logic fire
);
    localparam int unsigned MAXP  = (DATA_PERIOD > INSTR_PERIOD) ? DATA_PERIOD : INSTR_PERIOD;
    localparam int unsigned CNT_W = $clog2(MAXP + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // Pick the terminal count from the configured traffic class.
    assign limit = cfg_instr ? CNT_W'(INSTR_PERIOD - 1) : CNT_W'(DATA_PERIOD - 1);
    assign fire  = step && (cnt_q >= limit);

    // Advance or wrap the count on each counted reference.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (step) cnt_q <= fire ? '0 : cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/rfl_l1_tags.sv
// Direct-mapped L1 tag/valid/dirty store, indexed by the low line bits.
// Assumes: SETS is a power of two, at least 2; all accesses use look_line.
module rfl_l1_tags #(
    parameter int unsigned SETS   = 256,
    parameter int unsigned LINE_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] look_line,
    output logic              hit,
    output logic              cur_valid,
    output logic              cur_dirty,
    output logic [LINE_W-1:0] cur_line,
    input  logic              set_dirty,
    input  logic              install,
    input  logic              inst_dirty
);
    localparam int unsigned IDX_W = $clog2(SETS);
    localparam int unsigned TAG_W = LINE_W - IDX_W;

    logic [TAG_W-1:0] tag_q [SETS];
    logic [SETS-1:0]  valid_q;
    logic [SETS-1:0]  dirty_q;
    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;

    assign idx       = look_line[IDX_W-1:0];
    assign tag       = look_line[LINE_W-1:IDX_W];
    assign cur_valid = valid_q[idx];
    assign cur_dirty = dirty_q[idx];
    assign cur_line  = {tag_q[idx], idx};
    assign hit       = valid_q[idx] && (tag_q[idx] == tag);

    // Valid and dirty state per set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (install) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= inst_dirty;
        end else if (set_dirty) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    // Tag storage, written only on install.
    always_ff @(posedge clk) begin
        if (install) tag_q[idx] <= tag;
    end
endmodule

// File: rtl/rfl_filter.sv
// Fully-associative filter tag store with parallel compare, lowest-free
// fill and a round-robin replacement pointer.
// Assumes: LINES is a power of two; a line is held in at most one entry.
module rfl_filter #(
    parameter int unsigned LINES  = 32,
    parameter int unsigned LINE_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] look_line,
    output logic              hit,
    output logic              hit_dirty,
    output logic              vic_valid,
    output logic              vic_dirty,
    output logic [LINE_W-1:0] vic_line,
    input  logic              mark_dirty,
    input  logic              drop,
    input  logic              fill,
    input  logic              fill_dirty
);
    localparam int unsigned IDX_W = $clog2(LINES);

    logic [LINE_W-1:0] line_q [LINES];
    logic [LINES-1:0]  valid_q;
    logic [LINES-1:0]  dirty_q;
    logic [LINES-1:0]  match;
    logic [IDX_W-1:0]  rr_q;
    logic [IDX_W-1:0]  hit_idx;
    logic [IDX_W-1:0]  free_idx;
    logic [IDX_W-1:0]  vic_idx;
    logic              any_free;

    // One comparator per entry.
    for (genvar g = 0; g < LINES; g++) begin : g_cmp
        assign match[g] = valid_q[g] && (line_q[g] == look_line);
    end

    // Encode the matching entry and the lowest invalid entry.
    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        for (int i = 0; i < LINES; i++)
            if (match[i]) hit_idx = IDX_W'(i);
        for (int i = LINES - 1; i >= 0; i--)
            if (!valid_q[i]) free_idx = IDX_W'(i);
    end

    assign hit       = |match;
    assign hit_dirty = dirty_q[hit_idx];
    assign any_free  = ~&valid_q;
    assign vic_idx   = any_free ? free_idx : rr_q;
    assign vic_valid = valid_q[vic_idx];
    assign vic_dirty = dirty_q[vic_idx];
    assign vic_line  = line_q[vic_idx];

    // Entry state and replacement pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            rr_q    <= '0;
        end else if (fill) begin
            valid_q[vic_idx] <= 1'b1;
            dirty_q[vic_idx] <= fill_dirty;
            if (!any_free) rr_q <= rr_q + IDX_W'(1);
        end else if (drop) begin
            valid_q[hit_idx] <= 1'b0;
        end else if (mark_dirty) begin
            dirty_q[hit_idx] <= 1'b1;
        end
    end

    // Line addresses, written only on fill.
    always_ff @(posedge clk) begin
        if (fill) line_q[vic_idx] <= look_line;
    end
endmodule

// File: rtl/rfl_ctrl.sv
// Sampled-insertion controller: sequences L1, filter and L2 lookups for one
// outstanding reference, decides placement and reports dirty victims.
// Assumes: L2 answers each request exactly once with l2_rsp_valid.
module rfl_ctrl #(
    parameter int unsigned LINE_W       = 26,
    parameter int unsigned L1_SETS      = 256,
    parameter int unsigned FILT_LINES   = 32,
    parameter int unsigned DATA_PERIOD  = 20,
    parameter int unsigned INSTR_PERIOD = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_instr,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [LINE_W-1:0] req_line,
    input  logic              req_write,
    output logic              resp_valid,
    output logic [1:0]        resp_src,
    output logic              resp_to_l1,
    output logic              l2_req_valid,
    output logic [LINE_W-1:0] l2_req_line,
    input  logic              l2_rsp_valid,
    output logic              wb_valid,
    output logic [LINE_W-1:0] wb_line
);
    import rfl_pkg::*;

    state_e            st_q, st_d;
    logic [LINE_W-1:0] line_q;
    logic              wr_q, sel_q;

    logic              l1_hit, l1_cur_valid, l1_cur_dirty;
    logic [LINE_W-1:0] l1_cur_line;
    logic              l1_set_dirty, l1_install, l1_inst_dirty;
    logic              f_hit, f_hit_dirty, f_vic_valid, f_vic_dirty;
    logic [LINE_W-1:0] f_vic_line;
    logic              f_mark_dirty, f_drop, f_fill;
    logic              step, fire;

    logic              resp_d, to_l1_d, wb_d, l2_req_d;
    src_e              src_d;
    logic [LINE_W-1:0] wb_line_d;

    rfl_sampler #(.DATA_PERIOD(DATA_PERIOD), .INSTR_PERIOD(INSTR_PERIOD)) u_smp (
        .clk(clk), .rst_n(rst_n), .cfg_instr(cfg_instr), .step(step), .fire(fire)
    );

    rfl_l1_tags #(.SETS(L1_SETS), .LINE_W(LINE_W)) u_l1 (
        .clk(clk), .rst_n(rst_n), .look_line(line_q), .hit(l1_hit),
        .cur_valid(l1_cur_valid), .cur_dirty(l1_cur_dirty), .cur_line(l1_cur_line),
        .set_dirty(l1_set_dirty), .install(l1_install), .inst_dirty(l1_inst_dirty)
    );

    rfl_filter #(.LINES(FILT_LINES), .LINE_W(LINE_W)) u_flt (
        .clk(clk), .rst_n(rst_n), .look_line(line_q), .hit(f_hit), .hit_dirty(f_hit_dirty),
        .vic_valid(f_vic_valid), .vic_dirty(f_vic_dirty), .vic_line(f_vic_line),
        .mark_dirty(f_mark_dirty), .drop(f_drop), .fill(f_fill), .fill_dirty(wr_q)
    );

    assign req_ready   = (st_q == ST_IDLE);
    assign l2_req_line = line_q;

    // Lookup sequence, placement decision and victim selection.
    always_comb begin
        st_d          = st_q;
        step          = 1'b0;
        l1_set_dirty  = 1'b0;
        l1_install    = 1'b0;
        l1_inst_dirty = wr_q;
        f_mark_dirty  = 1'b0;
        f_drop        = 1'b0;
        f_fill        = 1'b0;
        resp_d        = 1'b0;
        src_d         = SRC_NONE;
        to_l1_d       = 1'b0;
        wb_d          = 1'b0;
        wb_line_d     = l1_cur_line;
        l2_req_d      = 1'b0;
        unique case (st_q)
            ST_IDLE: if (req_valid) st_d = ST_LOOK;
            ST_LOOK: begin
                if (l1_hit) begin
                    l1_set_dirty = wr_q;
                    resp_d       = 1'b1;
                    src_d        = SRC_L1;
                    to_l1_d      = 1'b1;
                    st_d         = ST_IDLE;
                end else begin
                    step = 1'b1;
                    if (f_hit) begin
                        resp_d = 1'b1;
                        src_d  = SRC_FILT;
                        st_d   = ST_IDLE;
                        if (fire) begin
                            l1_install    = 1'b1;
                            l1_inst_dirty = f_hit_dirty | wr_q;
                            f_drop        = 1'b1;
                            to_l1_d       = 1'b1;
                            wb_d          = l1_cur_valid && l1_cur_dirty;
                        end else begin
                            f_mark_dirty = wr_q;
                        end
                    end else begin
                        l2_req_d = 1'b1;
                        st_d     = ST_WAIT;
                    end
                end
            end
            ST_WAIT: if (l2_rsp_valid) begin
                resp_d = 1'b1;
                src_d  = SRC_L2;
                st_d   = ST_IDLE;
                if (sel_q) begin
                    l1_install = 1'b1;
                    to_l1_d    = 1'b1;
                    wb_d       = l1_cur_valid && l1_cur_dirty;
                end else begin
                    f_fill    = 1'b1;
                    wb_d      = f_vic_valid && f_vic_dirty;
                    wb_line_d = f_vic_line;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State, captured request and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= ST_IDLE;
            line_q       <= '0;
            wr_q         <= 1'b0;
            sel_q        <= 1'b0;
            resp_valid   <= 1'b0;
            resp_src     <= SRC_NONE;
            resp_to_l1   <= 1'b0;
            wb_valid     <= 1'b0;
            wb_line      <= '0;
            l2_req_valid <= 1'b0;
        end else begin
            st_q         <= st_d;
            resp_valid   <= resp_d;
            resp_src     <= src_d;
            resp_to_l1   <= to_l1_d;
            wb_valid     <= wb_d;
            wb_line      <= wb_line_d;
            l2_req_valid <= l2_req_d;
            if (st_q == ST_IDLE && req_valid) begin
                line_q <= req_line;
                wr_q   <= req_write;
            end
            if (st_q == ST_LOOK) sel_q <= fire;
        end
    end
endmodule

// File: rtl/rfl_checker.sv
// Protocol checker for rfl_ctrl, attached by bind.
// Assumes: the clock and active-low reset are shared with the controller.
module rfl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       resp_valid,
    input logic [1:0] resp_src,
    input logic       resp_to_l1,
    input logic       l2_req_valid,
    input logic       l2_rsp_valid,
    input logic       wb_valid
);
    p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_ready_with_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> req_ready);

    p_src_coded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_src != 2'd0));

    p_l1_hit_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_src == 2'd1) |-> resp_to_l1);

    p_l2_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        l2_req_valid |=> !l2_req_valid);

    p_l2_resp_follows_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_src == 2'd3) |-> $past(l2_rsp_valid));

    p_wb_only_on_insert_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (resp_valid && resp_src != 2'd1));
endmodule

bind rfl_ctrl rfl_checker u_rfl_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_src(resp_src), .resp_to_l1(resp_to_l1),
    .l2_req_valid(l2_req_valid), .l2_rsp_valid(l2_rsp_valid), .wb_valid(wb_valid)
);

// File: tb/tb_rfl_ctrl.sv
module tb_rfl_ctrl;
    localparam int LW = 26;
    localparam int SETS = 4;
    localparam int FL = 4;
    localparam int DP = 3;
    localparam int IP = 5;

    logic          clk = 1'b0, rst_n = 1'b0, cfg_instr = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0, l2_rsp_valid = 1'b0;
    logic [LW-1:0] req_line = '0;
    logic          req_ready, resp_valid, resp_to_l1, l2_req_valid, wb_valid;
    logic [1:0]    resp_src;
    logic [LW-1:0] l2_req_line, wb_line;

    rfl_ctrl #(.LINE_W(LW), .L1_SETS(SETS), .FILT_LINES(FL),
               .DATA_PERIOD(DP), .INSTR_PERIOD(IP)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_instr(cfg_instr), .req_valid(req_valid),
        .req_ready(req_ready), .req_line(req_line), .req_write(req_write),
        .resp_valid(resp_valid), .resp_src(resp_src), .resp_to_l1(resp_to_l1),
        .l2_req_valid(l2_req_valid), .l2_req_line(l2_req_line),
        .l2_rsp_valid(l2_rsp_valid), .wb_valid(wb_valid), .wb_line(wb_line)
    );

    always #2 clk = ~clk;

    typedef struct packed {
        logic [1:0]    src;
        logic          to_l1;
        logic          wb;
        logic [LW-1:0] wb_line;
        logic [31:0]   due;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0, n_bad = 0;
    int   cyc = 0;
    bit   finished = 0;

    // Reference model state.
    bit            m_l1v[SETS], m_l1d[SETS];
    logic [LW-1:0] m_l1ln[SETS];
    bit            m_fv[FL], m_fd[FL];
    logic [LW-1:0] m_fln[FL];
    int            m_rr = 0, m_ctr = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Monitor: pop and compare each response in its due cycle.
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (q.size() == 0) begin
                check(0, "R11", "response without request", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(cyc == int'(e.due), "R4", "response cycle", cyc, e.due);
                check(resp_src == e.src,
                      (e.src == 2'd1) ? "R2" : (e.src == 2'd2) ? "R3" : "R4",
                      "source", resp_src, e.src);
                check(resp_to_l1 == e.to_l1, "R5 R7", "placed in L1", resp_to_l1, e.to_l1);
                check(wb_valid == e.wb, "R8 R9 R10", "write-back strobe", wb_valid, e.wb);
                if (e.wb && wb_valid)
                    check(wb_line == e.wb_line, "R8 R9", "write-back line", wb_line, e.wb_line);
            end
        end
    end

    // Predict one reference from the requirements and update the model.
    task automatic predict(input logic [LW-1:0] ln, input bit wr, output exp_t e, output bit need);
        int idx, per, fi, slot;
        bit sel;
        idx  = int'(ln % SETS);
        per  = cfg_instr ? IP : DP;   // R6
        e    = '0;
        need = 0;
        fi   = -1;
        if (m_l1v[idx] && m_l1ln[idx] == ln) begin
            e.src = 2'd1; e.to_l1 = 1'b1;          // R2
            if (wr) m_l1d[idx] = 1;                 // R10
        end else begin
            sel   = (m_ctr >= per - 1);             // R5
            m_ctr = sel ? 0 : m_ctr + 1;
            for (int i = 0; i < FL; i++)
                if (m_fv[i] && m_fln[i] == ln) fi = i;
            if (fi >= 0) begin
                e.src = 2'd2;                        // R3
                if (sel) begin                       // R7
                    e.to_l1 = 1'b1;
                    if (m_l1v[idx] && m_l1d[idx]) begin e.wb = 1'b1; e.wb_line = m_l1ln[idx]; end
                    m_l1v[idx] = 1; m_l1ln[idx] = ln; m_l1d[idx] = m_fd[fi] | wr;
                    m_fv[fi] = 0;
                end else if (wr) m_fd[fi] = 1;
            end else begin
                e.src = 2'd3; need = 1;              // R4
                if (sel) begin
                    e.to_l1 = 1'b1;
                    if (m_l1v[idx] && m_l1d[idx]) begin e.wb = 1'b1; e.wb_line = m_l1ln[idx]; end
                    m_l1v[idx] = 1; m_l1ln[idx] = ln; m_l1d[idx] = wr;
                end else begin                       // R9
                    slot = -1;
                    for (int i = FL - 1; i >= 0; i--)
                        if (!m_fv[i]) slot = i;
                    if (slot < 0) begin
                        slot = m_rr;
                        if (m_fd[slot]) begin e.wb = 1'b1; e.wb_line = m_fln[slot]; end
                        m_rr = (m_rr + 1) % FL;
                    end
                    m_fv[slot] = 1; m_fln[slot] = ln; m_fd[slot] = wr;
                end
            end
        end
    endtask

    // Driver: issue one reference, queue its expectation, serve L2.
    task automatic do_ref(input logic [LW-1:0] ln, input bit wr, input int l2_delay);
        exp_t e;
        bit   need;
        int   acc;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_line = ln; req_write = wr;
        predict(ln, wr, e, need);
        @(negedge clk);
        req_valid = 1'b0;
        acc = cyc;
        check(!req_ready, "R11", "ready after accept", req_ready, 0);
        if (!need) begin
            e.due = 32'(acc + 1);
            q.push_back(e);
            @(negedge clk);
            check(!l2_req_valid, "R2", "no L2 request on hit", l2_req_valid, 0);
        end else begin
            @(negedge clk);
            check(l2_req_valid, "R4", "L2 request strobe", l2_req_valid, 1);
            check(l2_req_line == ln, "R4", "L2 request line", l2_req_line, ln);
            repeat (l2_delay) @(negedge clk);
            l2_rsp_valid = 1'b1;
            e.due = 32'(cyc + 1);
            q.push_back(e);
            @(negedge clk);
            l2_rsp_valid = 1'b0;
        end
        while (!req_ready) @(negedge clk);
    endtask

    task automatic summary();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < SETS; i++) begin m_l1v[i] = 0; m_l1d[i] = 0; m_l1ln[i] = '0; end
        for (int i = 0; i < FL; i++) begin m_fv[i] = 0; m_fd[i] = 0; m_fln[i] = '0; end
        repeat (4) @(negedge clk);
        // R1: idle outputs after reset
        check(req_ready, "R1", "ready in reset", req_ready, 1);
        check(!resp_valid && !l2_req_valid && !wb_valid, "R1", "strobes in reset",
              {resp_valid, l2_req_valid, wb_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !resp_valid, "R1", "idle after reset", {req_ready, resp_valid}, 2'b10);

        // Directed, period 3: fills go to filter, third miss goes to L1 (R5, R9)
        do_ref(26'd1, 1, 0);
        do_ref(26'd5, 0, 2);
        do_ref(26'd9, 0, 1);       // selected: L1 set 1
        do_ref(26'd9, 1, 0);       // R2 hit, R10 dirty
        do_ref(26'd1, 0, 0);       // R3 filter hit
        do_ref(26'd5, 0, 0);       // R3
        do_ref(26'd1, 0, 0);       // R7 promote, R8 dirty 9 written back
        do_ref(26'd13, 0, 3);      // R9 refills freed slot 0
        for (int i = 0; i < 6; i++) do_ref(LW'(16 + i * 4), i % 2, i % 3); // R9 round-robin

        // Mixed traffic, data period (R6)
        for (int i = 0; i < 300; i++)
            do_ref(LW'($urandom_range(0, 11)), bit'($urandom_range(0, 1)), $urandom_range(0, 3));

        // Instruction period (R6)
        cfg_instr = 1'b1;
        for (int i = 0; i < 300; i++)
            do_ref(LW'($urandom_range(0, 15)), bit'($urandom_range(0, 1)), $urandom_range(0, 2));

        repeat (4) @(negedge clk);
        check(q.size() == 0, "R11", "responses outstanding", q.size(), 0);
        summary();
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL R11 watchdog: actual %0d expected %0d", 200000, 0);
            summary();
        end
    end
endmodule